// File: doc/BRIEF.md
# Token-Passing Readout Handshake Port

This block is the master of a shared front-panel data bus for one module in a daisy chain of modules. A readout token arrives on `tok_in`. When a conversion has finished and the front-port readout mode is selected, the block raises a request and holds the token. It then drives its buffered 16-bit words onto the bus one at a time. Each word is handed to an external memory with a write strobe, which the memory answers with a write acknowledge. When the block has nothing to send, or once its last word has been taken, the token is handed on through `tok_out`.

The word source is a FIFO with a valid flag, a last-word flag and a pop strobe. The token and the acknowledge are asynchronous and pass through two-flop synchronizers. All timing is counted in cycles of a 100 MHz clock. The data is set up one cycle before the strobe. The strobe lasts at least five cycles and ends only once an acknowledge edge has been seen. A gap of at least six cycles follows each acknowledged word, so consecutive words are at least 13 cycles (130 ns) apart. If the token is withdrawn during a transfer, the bus is released and the unfinished word is kept. That word is sent again when the token returns.

Top module: `tok_rdout_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `req_o`, `stb_o`, `bus_oe`, `tok_out` and `done_o` are all 0.
- R2: A `conv_done` pulse sampled with `front_sel`=1 raises `req_o` in the next cycle. With `front_sel`=0 it leaves `req_o` at 0. `req_o` falls in the cycle after `done_o`.
- R3: With `req_o` low, `tok_out` copies `tok_in` with a delay of exactly two clock cycles.
- R4: While `req_o` is high, `tok_out` stays 0. It rises in the cycle after the last word's `done_o` if the token is still present.
- R5: `bus_oe` is high only while the synchronized token and `req_o` are both high. `stb_o` is high only while `bus_oe` is high.
- R6: A word is on `bus_o` with `bus_oe` high for at least one cycle (SETUP_CYC) before `stb_o` rises. `bus_o` does not change while `stb_o` is high.
- R7: Once raised, `stb_o` stays high for at least STB_CYC (5) cycles and until a rising edge of the synchronized `ack_in` is seen.
- R8: After an acknowledged word, `stb_o` stays low for at least GAP_CYC (6) cycles. Consecutive strobe rising edges are at least 13 cycles apart, which keeps the rate at or below 8 MHz.
- R9: Words leave in FIFO order with one `fifo_pop` per word. The readout ends after the word whose `fifo_last` flag was set.
- R10: A pulse on `ack_in` while `stb_o` is low does not shorten the next strobe.
- R11: If `tok_in` falls during a transfer, `stb_o` and `bus_oe` drop two cycles later. No further word is popped while the token is away. The interrupted word is sent again and every word is delivered once the token returns.
- R12: `done_o` is a single-cycle pulse at the end of the last word's gap. A `conv_done` (with `front_sel`=1) in that same cycle keeps `req_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | synchronous active-high reset |
| front_sel | input | 1 | mode bit: 1 selects front-port readout |
| conv_done | input | 1 | one-cycle pulse at end of conversion |
| fifo_valid | input | 1 | FIFO holds at least one word |
| fifo_data | input | 16 | word at the FIFO head |
| fifo_last | input | 1 | head word is the last of the event |
| fifo_pop | output | 1 | removes the head word |
| tok_in | input | 1 | readout token from upstream (asynchronous) |
| ack_in | input | 1 | write acknowledge from memory (asynchronous) |
| req_o | output | 1 | data waiting to be read |
| stb_o | output | 1 | write strobe to memory |
| bus_o | output | 16 | data bus value |
| bus_oe | output | 1 | data bus drive enable |
| tok_out | output | 1 | token passed downstream |
| done_o | output | 1 | one-cycle end-of-readout pulse |

## Verification
The hazardous overlap is the end of one event's readout meeting the start of the next. A new `conv_done` can land in the very cycle where the last word's gap expires and the pending request is cleared. The bench watches for the `done_o` pulse at a falling edge and drives `conv_done` for the rising edge that follows, so the set and the clear collide. It then judges that `req_o` stays high, that `tok_out` never rises in between, and that a freshly pushed word is read out normally afterwards.

// File: rtl/tok_rdout_pkg.sv
package tok_rdout_pkg;

    typedef enum logic [2:0] {
        TR_IDLE,
        TR_SETUP,
        TR_STROBE,
        TR_GAP,
        TR_HOLD
    } tr_state_e;

    function automatic int tr_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic tr_drives(input tr_state_e s);
        return (s == TR_SETUP) || (s == TR_STROBE) || (s == TR_GAP);
    endfunction

endpackage

// File: rtl/tr_sync.sv
module tr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[0] <= 1'b0;
                else     sh[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[i] <= 1'b0;
                else     sh[i] <= sh[i-1];
            end
        end
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/tr_timer.sv
module tr_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/tr_word.sv
module tr_word #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] d_in,
    input  logic          last_in,
    output logic [DW-1:0] d_q,
    output logic          last_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            d_q    <= '0;
            last_q <= 1'b0;
        end else if (capture) begin
            d_q    <= d_in;
            last_q <= last_in;
        end
    end
endmodule

// File: rtl/tok_rdout_port.sv
module tok_rdout_port
    import tok_rdout_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 1,
    parameter int STB_CYC     = 5,
    parameter int GAP_CYC     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              front_sel,
    input  logic              conv_done,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_last,
    output logic              fifo_pop,
    input  logic              tok_in,
    input  logic              ack_in,
    output logic              req_o,
    output logic              stb_o,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe,
    output logic              tok_out,
    output logic              done_o
);
    localparam int CNT_MAX = tr_max3(SETUP_CYC, STB_CYC, GAP_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] STB_LD   = CW'(STB_CYC - 1);
    localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYC - 1);

    logic ren_s, wak_s, wak_q, wak_rise;
    tr_state_e st, nxt;
    logic t_load, t_zero;
    logic [CW-1:0] t_val;
    logic ackd, ackd_set, ackd_clr;
    logic pend, finish;
    logic [DATA_W-1:0] word_q;
    logic last_q;
    logic drive;

    tr_sync #(.STAGES(SYNC_STAGES)) i_ren_sync (
        .clk(clk), .rst(rst), .d(tok_in), .q(ren_s)
    );

    tr_sync #(.STAGES(SYNC_STAGES)) i_wak_sync (
        .clk(clk), .rst(rst), .d(ack_in), .q(wak_s)
    );

    tr_timer #(.CW(CW)) i_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    tr_word #(.DW(DATA_W)) i_word (
        .clk(clk), .rst(rst), .capture(fifo_pop),
        .d_in(fifo_data), .last_in(fifo_last),
        .d_q(word_q), .last_q(last_q)
    );

    assign wak_rise = wak_s & ~wak_q;

    // Sequencer: one word per pass IDLE -> SETUP -> STROBE -> GAP.
    always_comb begin
        nxt      = st;
        t_load   = 1'b0;
        t_val    = '0;
        fifo_pop = 1'b0;
        ackd_set = 1'b0;
        ackd_clr = 1'b0;
        finish   = 1'b0;
        unique case (st)
            TR_IDLE: begin
                if (pend && ren_s && fifo_valid) begin
                    fifo_pop = 1'b1;
                    nxt      = TR_SETUP;
                    t_load   = 1'b1;
                    t_val    = SETUP_LD;
                end
            end
            TR_SETUP: begin
                if (!ren_s) begin
                    nxt = TR_HOLD;
                end else if (t_zero) begin
                    nxt      = TR_STROBE;
                    t_load   = 1'b1;
                    t_val    = STB_LD;
                    ackd_clr = 1'b1;
                end
            end
            TR_STROBE: begin
                if (!ren_s) begin
                    nxt = TR_HOLD;
                end else begin
                    if (wak_rise) ackd_set = 1'b1;
                    if (t_zero && (ackd || wak_rise)) begin
                        nxt    = TR_GAP;
                        t_load = 1'b1;
                        t_val  = GAP_LD;
                    end
                end
            end
            TR_GAP: begin
                if (t_zero) begin
                    nxt    = TR_IDLE;
                    finish = last_q;
                end
            end
            TR_HOLD: begin
                if (ren_s) begin
                    nxt    = TR_SETUP;
                    t_load = 1'b1;
                    t_val  = SETUP_LD;
                end
            end
            default: nxt = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TR_IDLE;
            wak_q <= 1'b0;
            ackd  <= 1'b0;
            pend  <= 1'b0;
        end else begin
            st    <= nxt;
            wak_q <= wak_s;
            if (ackd_clr)      ackd <= 1'b0;
            else if (ackd_set) ackd <= 1'b1;
            // a new conversion wins over the end of the previous readout
            if (conv_done && front_sel) pend <= 1'b1;
            else if (finish)            pend <= 1'b0;
        end
    end

    assign drive   = ren_s && tr_drives(st);
    assign bus_oe  = drive;
    assign bus_o   = drive ? word_q : '0;
    assign stb_o   = ren_s && (st == TR_STROBE);
    assign req_o   = pend;
    assign tok_out = ren_s && !pend;
    assign done_o  = finish;

endmodule

// File: rtl/tr_chk.sv
module tr_chk #(
    parameter int DATA_W  = 16,
    parameter int STB_CYC = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              front_sel,
    input logic              conv_done,
    input logic              req_o,
    input logic              stb_o,
    input logic              bus_oe,
    input logic              tok_out,
    input logic              done_o,
    input logic              ren_s,
    input logic [DATA_W-1:0] bus_o
);
    logic [7:0] hi_len;

    always_ff @(posedge clk) begin
        if (rst)          hi_len <= '0;
        else if (stb_o)   hi_len <= (hi_len == 8'hFF) ? hi_len : hi_len + 8'd1;
        else              hi_len <= '0;
    end

    a_r5_oe_needs_req: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> req_o) else $error("R5 bus driven without request");

    a_r5_stb_needs_oe: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> bus_oe) else $error("R5 strobe without bus drive");

    a_r6_data_hold: assert property (@(posedge clk) disable iff (rst)
        (stb_o && $past(stb_o)) |-> (bus_o == $past(bus_o))) else $error("R6 data moved under strobe");

    a_r6_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(stb_o) |-> $past(bus_oe)) else $error("R6 strobe without setup");

    a_r7_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(stb_o) && ren_s) |-> (hi_len >= 8'(STB_CYC))) else $error("R7 strobe too short");

    a_r4_tok_blocked: assert property (@(posedge clk) disable iff (rst)
        req_o |-> !tok_out) else $error("R4 token passed during request");

    a_r2_req_source: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> $past(conv_done && front_sel)) else $error("R2 request without conversion");

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) else $error("R12 done longer than one cycle");

    a_r12_done_clears: assert property (@(posedge clk) disable iff (rst)
        (done_o && !(conv_done && front_sel)) |=> !req_o) else $error("R12 request not cleared");

endmodule

bind tok_rdout_port tr_chk #(.DATA_W(DATA_W), .STB_CYC(STB_CYC)) i_tr_chk (
    .clk(clk), .rst(rst), .front_sel(front_sel), .conv_done(conv_done),
    .req_o(req_o), .stb_o(stb_o), .bus_oe(bus_oe), .tok_out(tok_out),
    .done_o(done_o), .ren_s(ren_s), .bus_o(bus_o)
);

// File: tb/test_tok_rdout_port.sv
module test_tok_rdout_port;
    localparam int CLK_PERIOD = 10;
    localparam int STB        = 5;
    localparam int GAP        = 6;
    localparam int MIN_PERIOD = 13;

    typedef struct packed {
        logic        sel;
        logic [3:0]  n;
        logic [3:0]  dly;
        logic [15:0] base;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd3, 4'd0, 16'h1234},
        '{1'b0, 4'd0, 4'd0, 16'h0000},
        '{1'b1, 4'd1, 4'd2, 16'hA5A5},
        '{1'b1, 4'd5, 4'd1, 16'h0F00},
        '{1'b0, 4'd0, 4'd0, 16'h0000},
        '{1'b1, 4'd2, 4'd7, 16'hFFFE}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic front_sel = 1'b0, conv_done = 1'b0, tok_in = 1'b0;
    logic ack_r = 1'b0, ack_x = 1'b0, ack_in;
    logic fifo_valid, fifo_last, fifo_pop;
    logic [15:0] fifo_data, bus_o;
    logic req_o, stb_o, bus_oe, tok_out, done_o;

    logic [15:0] fmem [16];
    logic [3:0]  f_rp = '0, f_wp = '0, e_ix = '0;

    int n_chk = 0, n_err = 0;
    int ack_dly_v = 0;

    assign ack_in     = ack_r | ack_x;
    assign fifo_valid = (f_rp != f_wp);
    assign fifo_data  = fmem[f_rp];
    assign fifo_last  = ((f_rp + 4'd1) == f_wp);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (fifo_pop) f_rp <= f_rp + 4'd1;

    tok_rdout_port i_tok_rdout_port (
        .clk(clk), .rst(rst), .front_sel(front_sel), .conv_done(conv_done),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_last(fifo_last),
        .fifo_pop(fifo_pop), .tok_in(tok_in), .ack_in(ack_in),
        .req_o(req_o), .stb_o(stb_o), .bus_o(bus_o), .bus_oe(bus_oe),
        .tok_out(tok_out), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // memory-side responder
    int wait_c = 0, hi_len = 0, lo_len = 100, per_len = 100;
    bit prev_stb = 0, prev_oe = 0, acked_now = 0, last_acked = 0;
    logic [15:0] prev_bus = '0;

    always @(negedge clk) begin
        if (rst) begin
            ack_r = 1'b0; prev_stb = 0; prev_oe = 0; acked_now = 0; last_acked = 0;
            lo_len = 100; per_len = 100;
        end else begin
            if (stb_o && !prev_stb) begin
                chk(prev_oe && (prev_bus == bus_o), "R6 setup before strobe", {15'd0, prev_oe, bus_o}, {15'd0, 1'b1, prev_bus});
                if (last_acked) begin
                    chk(lo_len >= GAP, "R8 gap after acknowledge", lo_len, GAP);
                    chk(per_len >= MIN_PERIOD, "R8 strobe period", per_len, MIN_PERIOD);
                end
                hi_len = 0; wait_c = 0; acked_now = 0; per_len = 0;
            end
            if (stb_o) begin
                hi_len++;
                if (prev_stb) chk(bus_o == prev_bus, "R6 data stable", bus_o, prev_bus);
                if (!ack_r) begin
                    if (wait_c >= ack_dly_v) begin
                        ack_r = 1'b1;
                        acked_now = 1;
                        chk(bus_o == fmem[e_ix], "R9 word order", bus_o, fmem[e_ix]);
                        e_ix = e_ix + 4'd1;
                    end else begin
                        wait_c++;
                    end
                end
            end else begin
                if (prev_stb) begin
                    if (acked_now) chk(hi_len >= STB, "R7 strobe width", hi_len, STB);
                    last_acked = acked_now;
                    lo_len = 0;
                end
                lo_len++;
                ack_r = 1'b0;
            end
            per_len++;
            prev_stb = stb_o; prev_oe = bus_oe; prev_bus = bus_o;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [15:0] w);
        fmem[f_wp] = w;
        f_wp = f_wp + 4'd1;
    endtask

    task automatic conv(input bit sel);
        front_sel = sel;
        conv_done = 1'b1;
        cyc(1);
        conv_done = 1'b0;
    endtask

    task automatic wait_done(output bit seen, output bit tok_bad);
        seen = 0; tok_bad = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done_o) begin
                seen = 1;
                return;
            end
            if (tok_out) tok_bad = 1;
            cyc(1);
        end
    endtask

    task automatic wait_stb();
        for (int i = 0; i < 200; i++) begin
            if (stb_o) return;
            cyc(1);
        end
    endtask

    task automatic finish_event(input string tag);
        bit seen, bad;
        wait_done(seen, bad);
        chk(seen, "R12 done pulse seen", seen, 1);
        chk(!bad, "R4 token held during readout", bad, 0);
        cyc(1);
        chk(done_o == 1'b0, "R12 done lasts one cycle", done_o, 0);
        chk(tok_out == 1'b1, "R4 token passed after last word", tok_out, 1);
        chk(req_o == 1'b0, "R2 request cleared", req_o, 0);
        chk(e_ix == f_wp, {tag, " all words delivered"}, e_ix, f_wp);
        chk(f_rp == f_wp, "R9 one pop per word", f_rp, f_wp);
    endtask

    task automatic run_all();
        logic [3:0] ix;
        cyc(3);
        chk({req_o, stb_o, bus_oe, tok_out, done_o} == 5'b0, "R1 outputs in reset", {req_o, stb_o, bus_oe, tok_out, done_o}, 0);
        rst = 1'b0;
        cyc(1);
        chk({req_o, stb_o, bus_oe, tok_out, done_o} == 5'b0, "R1 outputs after reset", {req_o, stb_o, bus_oe, tok_out, done_o}, 0);

        for (int k = 0; k < NV; k++) begin
            ack_dly_v = int'(VEC[k].dly);
            for (int i = 0; i < int'(VEC[k].n); i++)
                push(VEC[k].base + 16'(i) * 16'h0101);
            conv(VEC[k].sel);
            chk(req_o == VEC[k].sel, "R2 request follows mode bit", req_o, VEC[k].sel);
            tok_in = 1'b1;
            cyc(1);
            chk(tok_out == 1'b0, "R3 token two-cycle latency", tok_out, 0);
            cyc(1);
            if (!VEC[k].sel) begin
                chk(tok_out == 1'b1, "R3 token passes without request", tok_out, 1);
                chk(!stb_o && !bus_oe, "R5 no drive without request", {stb_o, bus_oe}, 0);
                tok_in = 1'b0;
                cyc(2);
                chk(tok_out == 1'b0, "R3 token release follows", tok_out, 0);
            end else begin
                finish_event("R9");
                tok_in = 1'b0;
                cyc(3);
            end
        end

        // R5 and R10: no token yet, spurious acknowledge while strobe is low
        ack_dly_v = 12;
        conv(1'b1);
        push(16'hBEEF);
        cyc(4);
        chk(!stb_o && !bus_oe, "R5 no drive without token", {stb_o, bus_oe}, 0);
        chk(f_rp != f_wp, "R5 word not taken without token", f_rp, f_wp);
        ack_x = 1'b1;
        cyc(4);
        ack_x = 1'b0;
        cyc(6);
        tok_in = 1'b1;
        wait_stb();
        cyc(STB + 3);
        chk(stb_o == 1'b1, "R10 stray acknowledge ignored", stb_o, 1);
        finish_event("R10");
        tok_in = 1'b0;
        cyc(3);

        // R11: token withdrawn during a strobe
        ack_dly_v = 9;
        push(16'h1111); push(16'h2222); push(16'h3333);
        conv(1'b1);
        tok_in = 1'b1;
        wait_stb();
        cyc(2);
        tok_in = 1'b0;
        cyc(2);
        chk(!stb_o && !bus_oe, "R11 bus released without token", {stb_o, bus_oe}, 0);
        chk(tok_out == 1'b0, "R4 token held while words remain", tok_out, 0);
        ix = e_ix;
        cyc(10);
        chk(e_ix == ix, "R11 nothing sent while token away", e_ix, ix);
        chk((f_wp - f_rp) == 4'd2, "R11 remaining words kept", f_wp - f_rp, 2);
        tok_in = 1'b1;
        ack_dly_v = 1;
        finish_event("R11");
        tok_in = 1'b0;
        cyc(3);

        // R12: new conversion in the cycle the last word completes
        ack_dly_v = 0;
        push(16'hC001); push(16'hC002);
        conv(1'b1);
        tok_in = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            if (done_o) break;
            cyc(1);
        end
        chk(done_o == 1'b1, "R12 done reached", done_o, 1);
        front_sel = 1'b1;
        conv_done = 1'b1;
        cyc(1);
        conv_done = 1'b0;
        chk(req_o == 1'b1, "R12 coincident conversion keeps request", req_o, 1);
        chk(tok_out == 1'b0, "R4 token kept for coincident event", tok_out, 0);
        chk(done_o == 1'b0, "R12 done single cycle", done_o, 0);
        push(16'h5A5A);
        finish_event("R12");
        tok_in = 1'b0;
        cyc(2);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule